// File: doc/BRIEF.md
# Oversampled Serial Receiver with Error-Tagged FIFO and Automatic RTS

The block turns an asynchronous serial line into characters. A baud-tick enable, pulsed by an external rate source at sixteen times the bit rate, paces a small state machine. The machine confirms a start bit halfway through it, shifts in 5 to 8 data bits with the least significant bit first, and optionally checks a parity bit. It then checks the stop bit. Every finished character goes into a receive FIFO together with three status flags: parity error, framing error and break.

The host drains the FIFO through a pop port. The head entry, the fill level and a sticky overrun flag are always visible. The FIFO capacity can be switched between a short and a long setting while running. In automatic flow-control mode, the RTS output is driven from the fill level compared against a programmable trigger level, so the far transmitter stops before the FIFO fills.

Top module: `uart_rx_autorts`

## Requirements
- R1: A start bit is accepted only if the line is still low when sampled 8 ticks after the falling edge was first seen. A shorter low pulse is discarded and produces no FIFO entry.
- R2: cfg_len selects the character length: 0, 1, 2 and 3 give 5, 6, 7 and 8 data bits. Bits arrive least significant first. The stored byte is right-aligned, and the unused upper bits are zero.
- R3: When cfg_par_en is 1, one parity bit follows the data. With cfg_par_odd at 0, the data bits plus the parity bit must hold an even number of ones; with cfg_par_odd at 1, an odd number. A mismatch sets the entry's parity-error flag. When cfg_par_en is 0, the flag is always 0.
- R4: A stop bit sampled low sets the entry's framing-error flag and keeps the received data. The receiver then waits for the line to go high before it looks for the next start.
- R5: A character whose data, parity and stop bits all sample low is a break. It is stored as one entry with data 0, the break flag 1 and both error flags 0. No further entry is stored until the line has returned high.
- R6: Entries leave the FIFO in arrival order. cfg_deep 0 gives a capacity of 16 entries and 1 gives 64. rx_level counts the stored entries. While the FIFO is empty, the head outputs are all zero.
- R7: A character that arrives while the FIFO is full is dropped and sets rx_overrun. rx_overrun stays set until the next accepted pop.
- R8: A change of cfg_deep empties the FIFO on the following clock edge.
- R9: With cfg_autorts at 1, rts goes low one clock after rx_level reaches cfg_trig or more, and returns high one clock after rx_level falls below cfg_trig. With cfg_autorts at 0, rts is high.
- R10: A pop while the FIFO is empty is ignored, and the next character is stored and read back normally.
- R11: After reset, rx_level is 0, rx_overrun is 0 and rts is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick16 | input | 1 | Enable pulse at 16 times the bit rate |
| rxd | input | 1 | Serial line, idle high |
| cfg_len | input | 2 | Character length select (5 + value bits) |
| cfg_par_en | input | 1 | Parity bit present and checked |
| cfg_par_odd | input | 1 | 1 for odd parity, 0 for even |
| cfg_deep | input | 1 | FIFO capacity: 0 gives 16, 1 gives 64 |
| cfg_autorts | input | 1 | Enables automatic RTS |
| cfg_trig | input | 7 | RTS trigger level |
| pop | input | 1 | Removes the head entry |
| rd_data | output | 8 | Head entry data |
| rd_perr | output | 1 | Head entry parity error |
| rd_ferr | output | 1 | Head entry framing error |
| rd_brk | output | 1 | Head entry break flag |
| rx_level | output | 7 | Number of stored entries |
| rx_overrun | output | 1 | Sticky overrun flag |
| rts | output | 1 | Ready-to-receive output |

## Verification
The bench sends a glitch on the line that is shorter than half a bit. A receiver that skipped the mid-start check would store a phantom character. A long low line must give exactly one break entry; a receiver without the wait-for-high state would keep storing zero entries, or would flag a framing error instead. The bench fills the short FIFO one entry past capacity and then switches depth. A design with a wrong full test or wrong wrap mask would corrupt the order, would overwrite the oldest entry, or would lose the overrun flag. RTS is checked at the exact trigger level, on both the falling and the rising side, where an off-by-one comparison shows up.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

  typedef struct packed {
    logic       brk;
    logic       ferr;
    logic       perr;
    logic [7:0] data;
  } rx_entry_t;

  typedef enum logic [2:0] {
    S_IDLE, S_START, S_DATA, S_PAR, S_STOP, S_HOLD
  } rx_state_t;

  // Number of data bits for a length select code.
  function automatic logic [3:0] char_len(input logic [1:0] sel);
    return 4'd5 + {2'b00, sel};
  endfunction

  // Bits enter at the top of the shifter; move them down to bit 0.
  function automatic logic [7:0] align_char(input logic [7:0] sh, input logic [1:0] sel);
    return sh >> (2'd3 - sel);
  endfunction

  // Parity bit the sender should have placed after the data.
  function automatic logic exp_parity(input logic [7:0] d, input logic odd);
    return (^d) ^ odd;
  endfunction

  // Ready-to-receive level for a given fill level.
  function automatic logic rts_next(input logic auto_en, input logic [6:0] lvl,
                                    input logic [6:0] trig);
    return !auto_en || (lvl < trig);
  endfunction

endpackage

// File: rtl/rx_sampler.sv
module rx_sampler
  import uart_rx_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      tick,
  input  logic      rxd,
  input  logic [1:0] len_sel,
  input  logic      par_en,
  input  logic      par_odd,
  output logic      push_o,
  output rx_entry_t entry_o
);
  localparam int CW = $clog2(OSR);
  localparam logic [CW-1:0] MID  = CW'(OSR/2 - 1);
  localparam logic [CW-1:0] LAST = CW'(OSR - 1);

  logic      rx_m, rx_s;
  rx_state_t state;
  logic [CW-1:0] cnt;
  logic [2:0] bitn;
  logic [7:0] sh;
  logic       allz;
  logic       parbit;
  logic [7:0] aligned;

  assign aligned = align_char(sh, len_sel);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_m <= 1'b1;
      rx_s <= 1'b1;
    end else begin
      rx_m <= rxd;
      rx_s <= rx_m;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      cnt     <= '0;
      bitn    <= '0;
      sh      <= '0;
      allz    <= 1'b0;
      parbit  <= 1'b0;
      push_o  <= 1'b0;
      entry_o <= '0;
    end else begin
      push_o <= 1'b0;
      if (tick) begin
        case (state)
          S_IDLE: begin
            if (!rx_s) begin
              state <= S_START;
              cnt   <= '0;
            end
          end
          S_START: begin
            if (cnt == MID) begin
              if (rx_s) begin
                state <= S_IDLE;
              end else begin
                state <= S_DATA;
                cnt   <= '0;
                bitn  <= '0;
                sh    <= '0;
                allz  <= 1'b1;
              end
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          S_DATA: begin
            if (cnt == LAST) begin
              cnt <= '0;
              sh  <= {rx_s, sh[7:1]};
              if (rx_s) allz <= 1'b0;
              if ({1'b0, bitn} == char_len(len_sel) - 4'd1)
                state <= par_en ? S_PAR : S_STOP;
              else
                bitn <= bitn + 1'b1;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          S_PAR: begin
            if (cnt == LAST) begin
              cnt    <= '0;
              parbit <= rx_s;
              if (rx_s) allz <= 1'b0;
              state  <= S_STOP;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          S_STOP: begin
            if (cnt == LAST) begin
              cnt    <= '0;
              push_o <= 1'b1;
              if (!rx_s && allz) begin
                entry_o <= '{brk: 1'b1, ferr: 1'b0, perr: 1'b0, data: 8'h00};
                state   <= S_HOLD;
              end else begin
                entry_o.brk  <= 1'b0;
                entry_o.ferr <= !rx_s;
                entry_o.perr <= par_en && (parbit != exp_parity(aligned, par_odd));
                entry_o.data <= aligned;
                state        <= rx_s ? S_IDLE : S_HOLD;
              end
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          S_HOLD: begin
            if (rx_s) state <= S_IDLE;
          end
          default: state <= S_IDLE;
        endcase
      end
    end
  end

endmodule

// File: rtl/rx_fifo.sv
module rx_fifo
  import uart_rx_pkg::*;
#(
  parameter int MAX_DEPTH   = 64,
  parameter int SMALL_DEPTH = 16
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      deep,
  input  logic      push,
  input  rx_entry_t wentry,
  input  logic      pop,
  output rx_entry_t head,
  output logic [$clog2(MAX_DEPTH+1)-1:0] level,
  output logic      overrun
);
  localparam int AW   = $clog2(MAX_DEPTH);
  localparam int CNTW = $clog2(MAX_DEPTH+1);

  rx_entry_t mem [MAX_DEPTH];
  logic [AW-1:0]   wp, rp, mask;
  logic [CNTW-1:0] cap;
  logic deep_q, flush, full, empty, do_push, do_pop;

  assign cap     = deep_q ? CNTW'(MAX_DEPTH) : CNTW'(SMALL_DEPTH);
  assign mask    = AW'(cap - 1'b1);
  assign flush   = deep != deep_q;
  assign full    = level == cap;
  assign empty   = level == '0;
  assign do_push = push && !full && !flush;
  assign do_pop  = pop && !empty && !flush;
  assign head    = empty ? '0 : mem[rp];

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= wentry;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      deep_q  <= 1'b0;
      wp      <= '0;
      rp      <= '0;
      level   <= '0;
      overrun <= 1'b0;
    end else begin
      deep_q <= deep;
      if (flush) begin
        wp    <= '0;
        rp    <= '0;
        level <= '0;
      end else begin
        if (do_push) wp <= (wp + 1'b1) & mask;
        if (do_pop)  rp <= (rp + 1'b1) & mask;
        level <= level + CNTW'(do_push) - CNTW'(do_pop);
      end
      if (push && full && !flush) overrun <= 1'b1;
      else if (do_pop)            overrun <= 1'b0;
    end
  end

endmodule

// File: rtl/rts_ctrl.sv
module rts_ctrl
  import uart_rx_pkg::*;
#(
  parameter int CNTW = 7
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            auto_en,
  input  logic [CNTW-1:0] level,
  input  logic [CNTW-1:0] trig,
  output logic            rts
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rts <= 1'b1;
    else        rts <= rts_next(auto_en, 7'(level), 7'(trig));
  end
endmodule

// File: rtl/uart_rx_autorts.sv
module uart_rx_autorts
  import uart_rx_pkg::*;
#(
  parameter int OSR         = 16,
  parameter int MAX_DEPTH   = 64,
  parameter int SMALL_DEPTH = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick16,
  input  logic       rxd,
  input  logic [1:0] cfg_len,
  input  logic       cfg_par_en,
  input  logic       cfg_par_odd,
  input  logic       cfg_deep,
  input  logic       cfg_autorts,
  input  logic [$clog2(MAX_DEPTH+1)-1:0] cfg_trig,
  input  logic       pop,
  output logic [7:0] rd_data,
  output logic       rd_perr,
  output logic       rd_ferr,
  output logic       rd_brk,
  output logic [$clog2(MAX_DEPTH+1)-1:0] rx_level,
  output logic       rx_overrun,
  output logic       rts
);
  localparam int CNTW = $clog2(MAX_DEPTH+1);

  logic      push_evt;
  rx_entry_t rx_ent;
  rx_entry_t head;

  rx_sampler #(.OSR(OSR)) u_samp (
    .clk(clk), .rst_n(rst_n), .tick(tick16), .rxd(rxd),
    .len_sel(cfg_len), .par_en(cfg_par_en), .par_odd(cfg_par_odd),
    .push_o(push_evt), .entry_o(rx_ent)
  );

  rx_fifo #(.MAX_DEPTH(MAX_DEPTH), .SMALL_DEPTH(SMALL_DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .deep(cfg_deep), .push(push_evt), .wentry(rx_ent),
    .pop(pop), .head(head), .level(rx_level), .overrun(rx_overrun)
  );

  rts_ctrl #(.CNTW(CNTW)) u_rts (
    .clk(clk), .rst_n(rst_n), .auto_en(cfg_autorts), .level(rx_level),
    .trig(cfg_trig), .rts(rts)
  );

  assign rd_data = head.data;
  assign rd_perr = head.perr;
  assign rd_ferr = head.ferr;
  assign rd_brk  = head.brk;

endmodule

// File: rtl/uart_rx_autorts_chk.sv
module uart_rx_autorts_chk
  import uart_rx_pkg::*;
#(
  parameter int MAX_DEPTH   = 64,
  parameter int SMALL_DEPTH = 16
) (
  input logic      clk,
  input logic      rst_n,
  input logic      cfg_deep,
  input logic      cfg_autorts,
  input logic [$clog2(MAX_DEPTH+1)-1:0] cfg_trig,
  input logic      push,
  input rx_entry_t ent,
  input logic      pop,
  input logic [$clog2(MAX_DEPTH+1)-1:0] level,
  input logic      overrun,
  input logic      rts
);
  localparam int CNTW = $clog2(MAX_DEPTH+1);

  logic            mode_q;
  logic            chg;
  logic [CNTW-1:0] room;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= 1'b0;
    else        mode_q <= cfg_deep;
  end
  assign chg  = cfg_deep != mode_q;
  assign room = mode_q ? CNTW'(MAX_DEPTH) : CNTW'(SMALL_DEPTH);

  p_break_entry_r5: assert property (@(posedge clk) disable iff (!rst_n)
    push && ent.brk |-> ent.data == 8'h00 && !ent.perr && !ent.ferr);

  p_level_cap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    level <= room);

  p_push_counts_r6: assert property (@(posedge clk) disable iff (!rst_n)
    push && !pop && !chg && level < room |=> level == $past(level) + 1'b1);

  p_overrun_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    push && !chg && level == room |=> overrun);

  p_drop_keeps_level_r7: assert property (@(posedge clk) disable iff (!rst_n)
    push && !pop && !chg && level == room |=> $stable(level));

  p_flush_r8: assert property (@(posedge clk) disable iff (!rst_n)
    chg |=> level == '0);

  p_rts_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_autorts && level >= cfg_trig |=> !rts);

  p_rts_free_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_autorts |=> rts);

  p_empty_pop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    pop && !push && level == '0 |=> level == '0);

endmodule

bind uart_rx_autorts uart_rx_autorts_chk #(.MAX_DEPTH(MAX_DEPTH), .SMALL_DEPTH(SMALL_DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_deep(cfg_deep), .cfg_autorts(cfg_autorts),
  .cfg_trig(cfg_trig), .push(push_evt), .ent(rx_ent), .pop(pop),
  .level(rx_level), .overrun(rx_overrun), .rts(rts)
);

// File: tb/uart_rx_autorts_tb.sv
module uart_rx_autorts_tb;
  localparam int CLK_PERIOD = 10;
  localparam int TDIV       = 2;
  localparam int BIT_CLKS   = 16 * TDIV;
  localparam int NVEC       = 10;

  // {len_sel[13:12], par_en[11], par_odd[10], data[9:2], bad_parity[1], stop_level[0]}
  localparam logic [13:0] VEC [NVEC] = '{
    {2'd3, 1'b0, 1'b0, 8'hA5, 1'b0, 1'b1},
    {2'd0, 1'b0, 1'b0, 8'h1F, 1'b0, 1'b1},
    {2'd1, 1'b1, 1'b0, 8'h2A, 1'b0, 1'b1},
    {2'd2, 1'b1, 1'b1, 8'h55, 1'b0, 1'b1},
    {2'd3, 1'b1, 1'b0, 8'hC3, 1'b1, 1'b1},
    {2'd3, 1'b1, 1'b1, 8'h80, 1'b1, 1'b1},
    {2'd0, 1'b1, 1'b1, 8'hFF, 1'b0, 1'b1},
    {2'd3, 1'b0, 1'b0, 8'h3C, 1'b0, 1'b0},
    {2'd2, 1'b1, 1'b0, 8'h01, 1'b0, 1'b0},
    {2'd1, 1'b0, 1'b0, 8'h00, 1'b0, 1'b1}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick16 = 1'b0;
  logic rxd = 1'b1;
  logic [1:0] cfg_len = 2'd3;
  logic cfg_par_en = 1'b0, cfg_par_odd = 1'b0, cfg_deep = 1'b0, cfg_autorts = 1'b0;
  logic [6:0] cfg_trig = 7'd0;
  logic pop = 1'b0;
  logic [7:0] rd_data;
  logic rd_perr, rd_ferr, rd_brk, rx_overrun, rts;
  logic [6:0] rx_level;

  int n_cmp = 0;
  int n_bad = 0;

  uart_rx_autorts u_dut (
    .clk(clk), .rst_n(rst_n), .tick16(tick16), .rxd(rxd), .cfg_len(cfg_len),
    .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd), .cfg_deep(cfg_deep),
    .cfg_autorts(cfg_autorts), .cfg_trig(cfg_trig), .pop(pop), .rd_data(rd_data),
    .rd_perr(rd_perr), .rd_ferr(rd_ferr), .rd_brk(rd_brk), .rx_level(rx_level),
    .rx_overrun(rx_overrun), .rts(rts)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(negedge clk) tick16 <= ~tick16;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic bit_time(input logic v);
    rxd = v;
    repeat (BIT_CLKS) @(negedge clk);
  endtask

  task automatic send_frame(input logic [1:0] sel, input logic pe, input logic po,
                            input logic [7:0] d, input logic bad, input logic stopb);
    int n;
    logic p;
    n = 5 + int'(sel);
    p = 1'b0;
    for (int i = 0; i < n; i++) p = p ^ d[i];
    p = p ^ po ^ bad;
    cfg_len = sel; cfg_par_en = pe; cfg_par_odd = po;
    bit_time(1'b0);
    for (int i = 0; i < n; i++) bit_time(d[i]);
    if (pe) bit_time(p);
    bit_time(stopb);
    bit_time(1'b1);
  endtask

  task automatic pop_one();
    pop = 1'b1;
    @(negedge clk);
    pop = 1'b0;
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    // R11: reset state
    check("R11 level", 32'(rx_level), 0);
    check("R11 overrun", 32'(rx_overrun), 0);
    check("R11 rts", 32'(rts), 1);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R6 empty head zero", 32'({rd_brk, rd_ferr, rd_perr, rd_data}), 0);

    // R2 R3 R4: table of frames
    for (int k = 0; k < NVEC; k++) begin
      logic [13:0] v;
      logic [7:0] mask;
      v = VEC[k];
      mask = 8'hFF >> (2'd3 - v[13:12]);
      send_frame(v[13:12], v[11], v[10], v[9:2], v[1], v[0]);
      check($sformatf("R6 level vec%0d", k), 32'(rx_level), 1);
      check($sformatf("R2 data vec%0d", k), 32'(rd_data), 32'(v[9:2] & mask));
      check($sformatf("R3 perr vec%0d", k), 32'(rd_perr), 32'(v[11] & v[1]));
      check($sformatf("R4 ferr vec%0d", k), 32'(rd_ferr), 32'(!v[0]));
      check($sformatf("R5 brk clear vec%0d", k), 32'(rd_brk), 0);
      pop_one();
    end

    // R1: short low pulse is not a start
    cfg_len = 2'd3; cfg_par_en = 1'b0;
    rxd = 1'b0;
    repeat (4 * TDIV) @(negedge clk);
    rxd = 1'b1;
    repeat (12 * BIT_CLKS) @(negedge clk);
    check("R1 false start", 32'(rx_level), 0);

    // R5: long low line gives one break entry
    bit_time(1'b0);
    repeat (11) bit_time(1'b0);
    check("R5 one entry", 32'(rx_level), 1);
    check("R5 brk flag", 32'(rd_brk), 1);
    check("R5 data zero", 32'(rd_data), 0);
    check("R5 no ferr", 32'(rd_ferr), 0);
    repeat (5) bit_time(1'b0);
    check("R5 still one", 32'(rx_level), 1);
    bit_time(1'b1);
    pop_one();
    check("R5 drained", 32'(rx_level), 0);

    // R10: pop on empty ignored
    pop_one();
    check("R10 level", 32'(rx_level), 0);
    send_frame(2'd3, 1'b0, 1'b0, 8'h6E, 1'b0, 1'b1);
    check("R10 level after", 32'(rx_level), 1);
    check("R10 data", 32'(rd_data), 32'h6E);
    pop_one();

    // R7: overrun on 16-deep
    for (int i = 0; i < 17; i++) send_frame(2'd3, 1'b0, 1'b0, 8'(i), 1'b0, 1'b1);
    check("R7 level full", 32'(rx_level), 16);
    check("R7 overrun set", 32'(rx_overrun), 1);
    check("R7 oldest kept", 32'(rd_data), 0);
    pop_one();
    check("R7 overrun cleared", 32'(rx_overrun), 0);
    check("R7 next data", 32'(rd_data), 1);

    // R8: depth switch flushes
    cfg_deep = 1'b1;
    repeat (2) @(negedge clk);
    check("R8 flush", 32'(rx_level), 0);

    // R6: 64-deep order
    for (int i = 0; i < 20; i++) send_frame(2'd3, 1'b0, 1'b0, 8'h40 + 8'(i), 1'b0, 1'b1);
    check("R6 deep level", 32'(rx_level), 20);
    check("R6 deep no overrun", 32'(rx_overrun), 0);
    for (int i = 0; i < 20; i++) begin
      check($sformatf("R6 order %0d", i), 32'(rd_data), 32'h40 + i);
      pop_one();
    end
    check("R6 drained", 32'(rx_level), 0);

    // R9: automatic RTS
    cfg_trig = 7'd3; cfg_autorts = 1'b1;
    repeat (3) @(negedge clk);
    check("R9 rts idle", 32'(rts), 1);
    send_frame(2'd3, 1'b0, 1'b0, 8'h11, 1'b0, 1'b1);
    send_frame(2'd3, 1'b0, 1'b0, 8'h22, 1'b0, 1'b1);
    check("R9 below trig", 32'(rts), 1);
    send_frame(2'd3, 1'b0, 1'b0, 8'h33, 1'b0, 1'b1);
    check("R9 at trig", 32'(rts), 0);
    pop_one();
    repeat (2) @(negedge clk);
    check("R9 back below", 32'(rts), 1);
    cfg_trig = 7'd1;
    repeat (2) @(negedge clk);
    check("R9 low trig", 32'(rts), 0);
    cfg_autorts = 1'b0;
    repeat (2) @(negedge clk);
    check("R9 auto off", 32'(rts), 1);

    finish_run();
  end
endmodule